// File: doc/BRIEF.md
# Latch-Based Two-Port Register Memory

This block is a small on-chip memory of `WORDS = 2**ADDR_W` words, each `DATA_W` bits wide, assembled only from ordinary logic cells. Every stored bit sits in a level-sensitive latch instead of a flip-flop. The block has one write port and one read port, and each finishes its work within one clock cycle. The default geometry is 128 words of 32 bits, a 4 kb array.

A write is captured in registers on the rising clock edge. The one-hot select for the target word then opens that word's latches only during the following low clock phase, when the captured address and data cannot change. A read decodes its address into a one-hot word select, gated by the read enable. That select drives a selection tree. The tree's first level is AOI22, and after that NAND2 and NOR2 levels alternate until a single output remains. Only the chosen branch of the tree toggles. The tree output is stored in the read-data register on the same rising edge at which the read address is sampled.

Top module: `lat_rf_2p`

## Requirements
- R1: A synchronous active-high reset clears the read-data output to all zeros, and the output is zero in the cycle after any clock edge at which reset is high.
- R2: A word written at one rising edge is returned by a read of that address sampled at any later rising edge, for every one of the `WORDS` addresses.
- R3: When a read and a write to the same address are sampled at the same rising edge, the read returns the contents that word held before that write.
- R4: Read data is registered. It changes only at a rising edge where the read enable is high, and then it shows the word selected by the read address sampled at that edge.
- R5: When the read enable is low at a rising edge, the read-data output keeps its previous value.
- R6: When the write enable is low at a rising edge, no word changes, whatever the write address and data are.
- R7: A write changes only the addressed word. All other words keep their contents.
- R8: The read word select has at most one bit set. It is all zeros when the read enable is low, and the selection tree then outputs zero.
- R9: At most one word's latch enable is open at any time, and it opens only during the low clock phase that follows the edge that captured the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; latches open only while it is low |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, sampled on the rising edge |
| wr_addr | input | ADDR_W | Word to write |
| wr_data | input | DATA_W | Data to write |
| rd_en | input | 1 | Read request, sampled on the rising edge |
| rd_addr | input | ADDR_W | Word to read |
| rd_data | output | DATA_W | Registered read result |

## Verification
A read and a write can both be sampled at the same rising edge, and they can target the same word. The bench sets this up on purpose: it sends a read and a write with new data to one address together, then reads that address again in the next cycle. The first read must return the old word and the second must return the new one. The reference model produces this by evaluating the read against its array before it applies the write. The bench also mixes random reads and writes to all addresses, sometimes with equal addresses, and compares against the same model at every clock.

// File: rtl/lat_rf_pkg.sv
package lat_rf_pkg;

  typedef enum logic [1:0] {
    GATE_AOI22 = 2'd0,
    GATE_NAND2 = 2'd1,
    GATE_NOR2  = 2'd2
  } tree_gate_e;

  // Level 0 pairs data with selects; later levels alternate NAND2 / NOR2.
  function automatic tree_gate_e gate_of_level(input int lvl);
    if (lvl == 0)
      return GATE_AOI22;
    else if ((lvl % 2) == 1)
      return GATE_NAND2;
    else
      return GATE_NOR2;
  endfunction

  // True when the output of the given level carries inverted OR polarity.
  function automatic bit level_inverted(input int lvl);
    return (lvl % 2) == 0;
  endfunction

endpackage

// File: rtl/lat_rf_onehot_dec.sv
module lat_rf_onehot_dec #(
  parameter int ADDR_W = 7,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORDS-1:0]  sel
);

  for (genvar w = 0; w < WORDS; w++) begin : g_sel
    assign sel[w] = en && (addr == ADDR_W'(w));
  end

endmodule

// File: rtl/lat_rf_array.sv
module lat_rf_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [WORDS-1:0][DATA_W-1:0]  words
);

  logic              wr_pend_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [WORDS-1:0]  wr_sel;
  logic [WORDS-1:0]  latch_en;

  // Capture stage: holds write inputs steady through the low phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend_q <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_pend_q <= wr_en;
      if (wr_en) begin
        wr_addr_q <= wr_addr;
        wr_data_q <= wr_data;
      end
    end
  end

  lat_rf_onehot_dec #(.ADDR_W(ADDR_W)) i_wdec (
    .en   (wr_pend_q),
    .addr (wr_addr_q),
    .sel  (wr_sel)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] cell_q;

    assign latch_en[w] = wr_sel[w] & ~clk;

    always_latch begin
      if (latch_en[w])
        cell_q <= wr_data_q;
    end

    assign words[w] = cell_q;
  end

  // R9: at most one word transparent during the low phase
  a_r9_single_latch_open: assert property (
    @(posedge clk) disable iff (rst) $onehot0(latch_en)
  ) else $error("R9: more than one word latch open");

  // R9: the pending-write decode addresses a single word
  a_r9_write_sel_onehot: assert property (
    @(posedge clk) disable iff (rst) $onehot0(wr_sel)
  ) else $error("R9: write select not one-hot");

  // R6: no write pending after a cycle without write enable
  a_r6_no_pend_without_en: assert property (
    @(posedge clk) disable iff (rst) !wr_en |=> (wr_sel == '0)
  ) else $error("R6: write select active without write enable");

endmodule

// File: rtl/lat_rf_read_tree.sv
module lat_rf_read_tree
  import lat_rf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic [WORDS-1:0]              sel,
  input  logic [WORDS-1:0][DATA_W-1:0]  words,
  output logic [DATA_W-1:0]             dout
);

  for (genvar k = 0; k < ADDR_W; k++) begin : g_lvl
    localparam int NODES = WORDS >> (k + 1);
    logic [NODES-1:0][DATA_W-1:0] node;

    for (genvar j = 0; j < NODES; j++) begin : g_node
      if (gate_of_level(k) == GATE_AOI22) begin : g_aoi
        assign node[j] = ~(({DATA_W{sel[2*j]}}   & words[2*j]) |
                           ({DATA_W{sel[2*j+1]}} & words[2*j+1]));
      end else if (gate_of_level(k) == GATE_NAND2) begin : g_nand
        assign node[j] = ~(g_lvl[k-1].node[2*j] & g_lvl[k-1].node[2*j+1]);
      end else begin : g_nor
        assign node[j] = ~(g_lvl[k-1].node[2*j] | g_lvl[k-1].node[2*j+1]);
      end
    end
  end

  if (level_inverted(ADDR_W - 1)) begin : g_out_inv
    assign dout = ~g_lvl[ADDR_W-1].node[0];
  end else begin : g_out_true
    assign dout = g_lvl[ADDR_W-1].node[0];
  end

  // R8: an idle select leaves the tree output at zero (immediate check)
  always_comb begin
    if (sel == '0)
      a_r8_idle_tree_zero: assert (dout == '0 || $isunknown(words))
        else $error("R8: tree output nonzero with no select");
  end

endmodule

// File: rtl/lat_rf_2p.sv
module lat_rf_2p #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [WORDS-1:0][DATA_W-1:0] words;
  logic [WORDS-1:0]             rd_sel;
  logic [DATA_W-1:0]            tree_out;

  lat_rf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .words   (words)
  );

  lat_rf_onehot_dec #(.ADDR_W(ADDR_W)) i_rdec (
    .en   (rd_en),
    .addr (rd_addr),
    .sel  (rd_sel)
  );

  lat_rf_read_tree #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tree (
    .sel   (rd_sel),
    .words (words),
    .dout  (tree_out)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= tree_out;
  end

  // R1: reset clears read data
  a_r1_reset_zero: assert property (
    @(posedge clk) rst |=> (rd_data == '0)
  ) else $error("R1: read data not cleared by reset");

  // R5: read data holds when read enable is low
  a_r5_hold_when_idle: assert property (
    @(posedge clk) disable iff (rst) !rd_en |=> $stable(rd_data)
  ) else $error("R5: read data changed without read enable");

  // R8: read select is one-hot or empty, and empty when idle
  a_r8_read_sel_onehot: assert property (
    @(posedge clk) disable iff (rst) $onehot0(rd_sel) && (rd_en || rd_sel == '0)
  ) else $error("R8: read select malformed");

endmodule

// File: tb/test_lat_rf_2p.sv
module test_lat_rf_2p;

  localparam int  ADDR_W   = 7;
  localparam int  DATA_W   = 32;
  localparam int  WORDS    = 1 << ADDR_W;
  localparam time CLK_HALF = 5ns;
  localparam int  WATCHDOG = 50000;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  logic [DATA_W-1:0] model [WORDS];
  logic [DATA_W-1:0] exp_rd;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #CLK_HALF clk = ~clk;

  lat_rf_2p #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_lat_rf_2p (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // One cycle: drive at the falling edge, update model at the rising edge,
  // compare at the next falling edge.
  task automatic step(input bit we, input int wa, input logic [DATA_W-1:0] wd,
                      input bit re, input int ra, input string req);
    wr_en   = we;
    wr_addr = ADDR_W'(wa);
    wr_data = wd;
    rd_en   = re;
    rd_addr = ADDR_W'(ra);
    @(posedge clk);
    if (re) exp_rd = model[ra];
    if (we) model[wa] = wd;
    @(negedge clk);
    check(req, rd_data, exp_rd);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_addr = '0; wr_data = '0; rd_en = 0; rd_addr = '0;
    exp_rd = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", rd_data, '0);
    rst = 1'b0;

    // R2: fill every word, then read every word back
    for (int a = 0; a < WORDS; a++)
      step(1, a, DATA_W'(32'hA5000000 ^ (a * 32'h01010101)), 0, 0, "R5 idle during fill");
    for (int a = 0; a < WORDS; a++)
      step(0, 0, '0, 1, a, "R2 readback");

    // R4: back-to-back reads at different addresses follow the address
    step(0, 0, '0, 1, 3, "R4 registered read");
    step(0, 0, '0, 1, WORDS - 1, "R4 registered read");

    // R3: read and write of the same address at one edge
    step(1, 17, 32'hDEADBEEF, 1, 17, "R3 read-during-write old");
    step(0, 0, '0, 1, 17, "R3 new value next cycle");
    step(1, 0, 32'h12345678, 1, 0, "R3 read-during-write word 0");
    step(0, 0, '0, 1, 0, "R3 new value word 0");

    // R5: read enable low keeps output while address wiggles
    step(0, 0, '0, 0, 5, "R5 hold");
    step(1, 9, 32'h0F0F0F0F, 0, 9, "R5 hold during write");

    // R6: write enable low with live address/data changes nothing
    step(0, 40, 32'hFFFFFFFF, 0, 0, "R6 disabled write");
    step(0, 0, '0, 1, 40, "R6 word unchanged");

    // R7: write one word, neighbours keep their contents
    step(1, 64, 32'h00C0FFEE, 0, 0, "R7 write");
    step(0, 0, '0, 1, 63, "R7 neighbour below");
    step(0, 0, '0, 1, 65, "R7 neighbour above");
    step(0, 0, '0, 1, 64, "R7 target");

    // R1: reset mid-run clears output
    rst = 1'b1;
    @(posedge clk); exp_rd = '0;
    @(negedge clk);
    check("R1 reset mid-run", rd_data, '0);
    rst = 1'b0;

    // R2/R3/R9: random interleaved traffic, frequent address collisions
    for (int n = 0; n < 3000; n++) begin
      int wa = int'($urandom_range(WORDS - 1));
      int ra = ($urandom_range(3) == 0) ? wa : int'($urandom_range(WORDS - 1));
      step(bit'($urandom_range(1)), wa, DATA_W'($urandom),
           bit'($urandom_range(1)), ra, "R2 random traffic");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule